// File: doc/BRIEF.md
# Timer Interrupt Edge-to-Pending Router

This block turns the level-sensitive interrupt outputs of per-core timers and watchdogs into set-pending requests for an interrupt controller's private-interrupt inputs. Each core owns two lines. The even line of a pair is the timer and the odd line is the watchdog. The block keeps the last sampled level of every line. When a line goes from low to high, the block queues one request. A line that stays high raises nothing more.

Queued requests are held in a per-line pending register. A fixed-priority arbiter gives the lowest line index first. The chosen request goes into an output register, which presents a valid flag, the target core number and the private interrupt ID. That register holds its contents until the controller asserts ready. Each line has only one pending bit, so a line that rises again while its request is still queued merges into the existing request. Lines that belong to cores beyond the configured core count are ignored.

Top module: `tirq_edge_router`

## Requirements
- R1: A request is raised only on a low-to-high change of a line. A line held high for any number of cycles produces no further request.
- R2: The core field of a request equals the line index shifted right by one (lines 2k and 2k+1 go to core k).
- R3: The 5-bit ID field of a request is 29 for an even line (timer) and 30 for an odd line (watchdog).
- R4: Reset clears every stored line level and every queued request, and valid is low during reset. A line that is already high when reset is released gives exactly one request.
- R5: Lines with index at or above twice NUM_CORES never produce a request, whatever their level.
- R6: Edges that occur together are all delivered, one per cycle while ready is high, in ascending line order.
- R7: While valid is high and ready is low, valid, core and ID stay unchanged.
- R8: Any number of further rising edges on a line whose request is queued and not yet issued add no second request.
- R9: With nothing queued and the output register empty, a line first sampled high at clock edge k gives valid high after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 8 | Level interrupt lines; line 2k is the timer and 2k+1 the watchdog of core k |
| req_ready_i | input | 1 | Controller accepts the presented request |
| req_valid_o | output | 1 | A set-pending request is presented |
| req_core_o | output | 2 | Target core of the request |
| req_id_o | output | 5 | Private interrupt ID of the request |

## Verification
The bench builds the router twice. The first instance uses NUM_CORES = 4, so that all 256 combinations of simultaneous rising edges can be swept. For each combination the bench checks the full delivery order and the core and ID fields against arithmetic from the line index. The second instance uses NUM_CORES = 2, which puts four lines into the ignored range. That makes it possible to show that those lines never produce a request, while a configured line next to them still does. Directed sequences with ready held low cover output holding, merging of repeated edges, and a line that is already high when reset is released.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int MAX_CORES      = 4;
  localparam int LINES_PER_CORE = 2;
  localparam int MAX_LINES      = MAX_CORES * LINES_PER_CORE;
  localparam int IDX_W          = $clog2(MAX_LINES);
  localparam int CORE_W         = $clog2(MAX_CORES);
  localparam int ID_W           = 5;
  localparam int TIMER_PPI_ID   = 29;

  typedef logic [IDX_W-1:0]     line_idx_t;
  typedef logic [MAX_LINES-1:0] line_vec_t;
endpackage

// File: rtl/tirq_edge_det.sv
module tirq_edge_det #(
  parameter int N_LINES  = 8,
  parameter int N_ACTIVE = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] rise_o
);
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] prev_d;
  logic [N_LINES-1:0] act_mask;

  // Lines above the configured range are masked out.
  for (genvar g = 0; g < N_LINES; g++) begin : g_mask
    if (g < N_ACTIVE) begin : g_on
      assign act_mask[g] = 1'b1;
    end else begin : g_off
      assign act_mask[g] = 1'b0;
    end
  end

  // Every stored level follows its line each cycle, edge or not.
  always_comb begin
    prev_d = line_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  assign rise_o = line_i & ~prev_q & act_mask;
endmodule

// File: rtl/tirq_pend_q.sv
module tirq_pend_q #(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] set_i,
  input  logic [N_LINES-1:0] grant_i,
  output logic [N_LINES-1:0] pend_o
);
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] pend_d;
  logic               pend_en;

  // A new rise on an already pending line folds into that bit.
  always_comb begin
    pend_en = |set_i || |grant_i;
    pend_d  = (pend_q & ~grant_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  a_r6_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));
  a_r6_grant_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i & ~pend_q) == '0);

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    a_r8_kept_until_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[g] && !grant_i[g]) |=> pend_q[g]);
  end
endmodule

// File: rtl/tirq_prio_arb.sv
module tirq_prio_arb #(
  parameter int N_LINES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [N_LINES-1:0] req_i,
  input  logic               en_i,
  output logic [N_LINES-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  logic [N_LINES-1:0] low_bit;

  assign any_o   = |req_i;
  assign low_bit = req_i & (~req_i + 1'b1);
  assign grant_o = en_i ? low_bit : '0;

  // Lowest set index wins.
  always_comb begin
    idx_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/tirq_edge_router.sv
module tirq_edge_router
  import tirq_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [MAX_LINES-1:0] line_i,
  input  logic                 req_ready_i,
  output logic                 req_valid_o,
  output logic [CORE_W-1:0]    req_core_o,
  output logic [ID_W-1:0]      req_id_o
);
  localparam int ACTIVE_LINES = NUM_CORES * LINES_PER_CORE;

  line_vec_t rise;
  line_vec_t pend;
  line_vec_t grant;
  line_idx_t win_idx;
  logic      win_any;
  logic      take;

  logic      vld_q, vld_d;
  line_idx_t idx_q, idx_d;
  logic      out_en;

  tirq_edge_det #(.N_LINES(MAX_LINES), .N_ACTIVE(ACTIVE_LINES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_i),
    .rise_o(rise)
  );

  tirq_pend_q #(.N_LINES(MAX_LINES)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (rise),
    .grant_i(grant),
    .pend_o (pend)
  );

  tirq_prio_arb #(.N_LINES(MAX_LINES), .IDX_W(IDX_W)) u_arb (
    .req_i  (pend),
    .en_i   (take),
    .grant_o(grant),
    .idx_o  (win_idx),
    .any_o  (win_any)
  );

  // Output slot: refilled when empty or when its request is accepted.
  always_comb begin
    take   = !vld_q || req_ready_i;
    out_en = take;
    vld_d  = win_any;
    idx_d  = win_any ? win_idx : idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else if (out_en) begin
      vld_q <= vld_d;
      idx_q <= idx_d;
    end
  end

  assign req_valid_o = vld_q;
  assign req_core_o  = idx_q[IDX_W-1:1];
  assign req_id_o    = ID_W'(TIMER_PPI_ID) + ID_W'(idx_q[0]);

  a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_core_o) && $stable(req_id_o)));
  a_r5_core_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (int'(req_core_o) < NUM_CORES));
  a_r3_id_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_id_o == ID_W'(29) || req_id_o == ID_W'(30)));
endmodule

// File: tb/sim_tirq_edge_router.sv
`timescale 1ns/1ps
module sim_tirq_edge_router;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] lines0, lines1;
  logic       ready0;
  logic       v0, v1;
  logic [1:0] core0, core1;
  logic [4:0] id0, id1;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tirq_edge_router #(.NUM_CORES(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_i(lines0), .req_ready_i(ready0),
    .req_valid_o(v0), .req_core_o(core0), .req_id_o(id0));

  tirq_edge_router #(.NUM_CORES(2)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .line_i(lines1), .req_ready_i(1'b1),
    .req_valid_o(v1), .req_core_o(core1), .req_id_o(id1));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic expect_req(string r, int idx);
    chk(v0 == 1'b1, r, int'(v0), 1);
    chk(int'(core0) == (idx >> 1), "R2 core", int'(core0), idx >> 1);
    chk(int'(id0) == 29 + (idx & 1), "R3 id", int'(id0), 29 + (idx & 1));
  endtask

  task automatic expect_idle(string r);
    chk(v0 == 1'b0, r, int'(v0), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lines0 = '0; lines1 = '0; ready0 = 1'b1;
    step(); step();
    chk(v0 == 1'b0, "R4 reset valid u0", int'(v0), 0);
    chk(v1 == 1'b0, "R4 reset valid u1", int'(v1), 0);
    rst_n = 1'b1;
    step();

    // R6/R9/R1: every combination of simultaneous rises, ready high
    for (int m = 1; m < 256; m++) begin
      lines0 = m[7:0];
      step();
      expect_idle("R9 one edge after rise");
      step();
      for (int b = 0; b < 8; b++) begin
        if (m[b]) begin
          expect_req("R6 order", b);
          step();
        end
      end
      expect_idle("R1 held high no repeat");
      step();
      expect_idle("R1 held high no repeat later");
      lines0 = '0;
      step(); step();
    end

    // R7: backpressure holds the presented request
    ready0 = 1'b0;
    lines0 = 8'h08;
    step(); step();
    expect_req("R7 present", 3);
    lines0 = 8'h0A;
    for (int k = 0; k < 3; k++) begin
      step();
      expect_req("R7 held", 3);
    end
    ready0 = 1'b1;
    step();
    expect_req("R6 queued after hold", 1);
    step();
    expect_idle("R7 drained");
    lines0 = '0;
    step(); step();

    // R8: repeated rises on a queued line merge
    ready0 = 1'b0;
    lines0 = 8'h01;
    step(); step();
    expect_req("R8 blocker", 0);
    lines0 = 8'h21; step();
    lines0 = 8'h01; step();
    lines0 = 8'h21; step();
    lines0 = 8'h01; step();
    lines0 = 8'h21; step();
    expect_req("R8 blocker still", 0);
    ready0 = 1'b1;
    step();
    expect_req("R8 merged once", 5);
    step();
    expect_idle("R8 no second request");
    step();
    expect_idle("R8 no second request later");
    lines0 = '0;
    step(); step();

    // R4: line high across reset yields one request
    lines0 = 8'h04;
    rst_n = 1'b0;
    step();
    expect_idle("R4 in reset");
    step();
    expect_idle("R4 in reset");
    rst_n = 1'b1;
    step();
    expect_idle("R4 after release");
    step();
    expect_req("R4 high at release", 2);
    step();
    expect_idle("R4 single request");
    step();
    expect_idle("R4 single request later");
    lines0 = '0;
    step();

    // R5: unconfigured lines on the 2-core instance
    lines1 = 8'hF0;
    for (int k = 0; k < 4; k++) begin
      step();
      chk(v1 == 1'b0, "R5 ignored lines", int'(v1), 0);
    end
    lines1 = 8'h00; step();
    lines1 = 8'hF2;
    step();
    chk(v1 == 1'b0, "R5 configured pending", int'(v1), 0);
    step();
    chk(v1 == 1'b1, "R5 configured line valid", int'(v1), 1);
    chk(core1 == 2'd0, "R2 core u1", int'(core1), 0);
    chk(id1 == 5'd30, "R3 id u1", int'(id1), 30);
    step();
    chk(v1 == 1'b0, "R5 nothing from ignored", int'(v1), 0);
    step();
    chk(v1 == 1'b0, "R5 nothing from ignored later", int'(v1), 0);
    lines1 = '0;
    step();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule